// File: doc/BRIEF.md
# Audio Link Codec-Side Input Frame Serializer

This block sits on the codec side of a fixed-rate, time-division audio serial link. It builds the frame that the codec returns to the controller and shifts that frame out one bit per bit clock. Each frame is 256 bits long. A 16-bit tag slot comes first, followed by twelve 20-bit data slots. The tag slot carries a codec-ready flag and one valid flag for each data slot. The data slots carry the answer to a register read (the echoed index and the read data) and three 16-bit record samples: left, right and microphone.

The controller marks each frame by raising SYNC. The block samples SYNC on falling edges of the bit clock. When it sees SYNC go from low to high, it drives the first frame bit on the next rising edge and then one bit on each rising edge after that, most significant bit first. The record samples and their valid flags are captured when the frame starts. A register read request can arrive at any time. It is answered in the frame that follows the one in which it arrived. For a set number of frames after reset, the codec reports not-ready and every tag is zero.

Top module: `aclink_tx_frame`

## Requirements
- R1: While reset is held, and afterwards until the first frame start, `sdata_in` is 0.
- R2: A frame starts on the rising edge that follows a falling edge at which `sync` is sampled high, when `sync` was sampled low at the falling edge before that. Frame bit 0 (the codec-ready flag) is on `sdata_in` right after that rising edge.
- R3: A frame is 256 bits long, one per rising edge, MSB first. The 16-bit tag slot comes first, then data slots 1 to 12 of 20 bits each. After the last bit, `sdata_in` is 0 until the next frame start.
- R4: In the tag slot, bit 15 is codec-ready and bit 15-n is the valid flag of data slot n (n = 1..12). Bits 2:0 are 0.
- R5: Codec-ready is 0 in the first READY_FRAMES frames after reset. In those frames every tag is 0 and the whole frame is zero.
- R6: Slot 1, when valid, carries the 7-bit register index in bits 18:12. Bit 19 and bits 11:0 are 0.
- R7: Slot 2, when valid, carries the 16-bit read data in bits 19:4. Bits 3:0 are 0.
- R8: Slots 3, 4 and 6 carry the left, right and microphone samples in bits 19:4, with bits 3:0 zero. Each of these slots is tagged valid when its bit of `rec_vld` (bit 0 left, bit 1 right, bit 2 microphone) is 1 at the frame start edge and the codec is ready. Samples are captured at that edge.
- R9: Every slot tagged invalid is all zeros. Slots 5 and 7 to 12 are always zero and never tagged.
- R10: A read request sampled on a rising edge before a frame start is answered in slots 1 and 2 of that ready frame, and those slots are tagged valid in that frame only. A request sampled on the start edge itself, or during the frame, waits for the next frame. A request made during not-ready frames is held until the first ready frame.
- R11: When several requests arrive before the frame that answers them, the index and data of the last one are returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; data changes on rising edges, SYNC sampled on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker from the controller |
| rd_req | input | 1 | One-cycle register read answer request |
| rd_index | input | 7 | Register index to echo |
| rd_data | input | 16 | Register contents to return |
| rec_left | input | 16 | Left record sample |
| rec_right | input | 16 | Right record sample |
| rec_mic | input | 16 | Microphone record sample |
| rec_vld | input | 3 | Sample valid flags: bit 0 left, bit 1 right, bit 2 microphone |
| sdata_in | output | 1 | Serial frame output to the controller |

## Verification
The bench goes after the edges of the read handshake. It issues a request on the first rising edge of a frame, and a design that answered it at once would tag slots 1 and 2 one frame early. It issues two requests back to back before a frame, where keeping the first would echo a stale index. It issues a request while the codec is still not ready, where dropping it would leave slots 1 and 2 empty in the first ready frame. It also checks that the answer does not repeat in the frame after it. Random frames with mixed sample valid flags expose any tag placed one bit off, any missing zero fill in invalid or reserved slots, and any frame started one edge early or late, which shifts every field.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;

    localparam int SLOT_W  = 20;
    localparam int TAG_W   = 16;
    localparam int SMP_W   = 16;
    localparam int IDX_W   = 7;
    localparam int LAST_SL = 12;

    typedef struct packed {
        logic              ready;
        logic              rd_vld;
        logic [IDX_W-1:0]  idx;
        logic [SMP_W-1:0]  rdata;
        logic [2:0]        rec_vld;
        logic [SMP_W-1:0]  left;
        logic [SMP_W-1:0]  right;
        logic [SMP_W-1:0]  mic;
    } frame_t;

    typedef struct packed {
        logic       in_frame;
        logic [3:0] slot;
        logic [4:0] bitp;
    } pos_t;

    // tag slot: ready at bit 15, slot n flag at bit 15-n
    function automatic logic [TAG_W-1:0] tag_word(input frame_t f);
        logic [TAG_W-1:0] t;
        t       = '0;
        t[15]   = f.ready;
        t[14]   = f.rd_vld;
        t[13]   = f.rd_vld;
        t[12]   = f.rec_vld[0];
        t[11]   = f.rec_vld[1];
        t[9]    = f.rec_vld[2];
        return t;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_word(input frame_t f, input logic [3:0] s);
        logic [SLOT_W-1:0] w;
        w = '0;
        case (s)
            4'd1: if (f.rd_vld)     w = {1'b0, f.idx, 12'h000};
            4'd2: if (f.rd_vld)     w = {f.rdata, 4'h0};
            4'd3: if (f.rec_vld[0]) w = {f.left, 4'h0};
            4'd4: if (f.rec_vld[1]) w = {f.right, 4'h0};
            4'd6: if (f.rec_vld[2]) w = {f.mic, 4'h0};
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/aclink_tx_edge.sv
module aclink_tx_edge (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic sync,
    output logic start
);
    typedef struct packed {
        logic now;
        logic prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.now  = sync;
        smp_d.prev = smp_q.now;
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign start = smp_q.now & ~smp_q.prev;

endmodule

// File: rtl/aclink_tx_pos.sv
module aclink_tx_pos
    import aclink_tx_pkg::*;
(
    input  logic bit_clk,
    input  logic rst_n,
    input  logic start,
    output pos_t pos_d,
    output pos_t pos_q
);
    always_comb begin
        pos_d = pos_q;
        if (start) begin
            pos_d.in_frame = 1'b1;
            pos_d.slot     = 4'd0;
            pos_d.bitp     = 5'd15;
        end else if (pos_q.in_frame) begin
            if (pos_q.bitp == 5'd0) begin
                if (pos_q.slot == 4'(LAST_SL)) begin
                    pos_d.in_frame = 1'b0;
                end else begin
                    pos_d.slot = pos_q.slot + 4'd1;
                    pos_d.bitp = 5'(SLOT_W - 1);
                end
            end else begin
                pos_d.bitp = pos_q.bitp - 5'd1;
            end
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assert_first_bit_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        start |=> (pos_q.in_frame && pos_q.slot == 4'd0 && pos_q.bitp == 5'd15));

    assert_frame_end_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pos_q.in_frame && pos_q.slot == 4'(LAST_SL) && pos_q.bitp == 5'd0 && !start)
        |=> !pos_q.in_frame);

endmodule

// File: rtl/aclink_tx_frame.sv
module aclink_tx_frame
    import aclink_tx_pkg::*;
#(
    parameter int READY_FRAMES = 2
) (
    input  logic        bit_clk,
    input  logic        rst_n,
    input  logic        sync,
    input  logic        rd_req,
    input  logic [6:0]  rd_index,
    input  logic [15:0] rd_data,
    input  logic [15:0] rec_left,
    input  logic [15:0] rec_right,
    input  logic [15:0] rec_mic,
    input  logic [2:0]  rec_vld,
    output logic        sdata_in
);
    localparam int CNT_W = $clog2(READY_FRAMES + 2);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(READY_FRAMES);

    typedef struct packed {
        frame_t            cont;
        logic              pend;
        logic [IDX_W-1:0]  pidx;
        logic [SMP_W-1:0]  pdata;
        logic [CNT_W-1:0]  cnt;
        logic              sdata;
    } st_t;

    logic start;
    pos_t pos_d, pos_q;
    st_t  st_d, st_q;

    aclink_tx_edge u_edge (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .sync    (sync),
        .start   (start)
    );

    aclink_tx_pos u_pos (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .start   (start),
        .pos_d   (pos_d),
        .pos_q   (pos_q)
    );

    always_comb begin
        logic              ready_now;
        logic [TAG_W-1:0]  tw;
        logic [SLOT_W-1:0] sw;
        st_d      = st_q;
        ready_now = (st_q.cnt == CNT_TOP);

        if (rd_req) begin
            st_d.pend  = 1'b1;
            st_d.pidx  = rd_index;
            st_d.pdata = rd_data;
        end

        if (start) begin
            if (!ready_now) st_d.cnt = st_q.cnt + 1'b1;
            st_d.cont.ready   = ready_now;
            st_d.cont.rd_vld  = ready_now & st_q.pend;
            st_d.cont.idx     = st_q.pidx;
            st_d.cont.rdata   = st_q.pdata;
            st_d.cont.rec_vld = ready_now ? rec_vld : 3'b000;
            st_d.cont.left    = rec_left;
            st_d.cont.right   = rec_right;
            st_d.cont.mic     = rec_mic;
            if (ready_now && !rd_req) st_d.pend = 1'b0;
        end

        tw = tag_word(st_d.cont);
        sw = slot_word(st_d.cont, pos_d.slot);
        if (!pos_d.in_frame)          st_d.sdata = 1'b0;
        else if (pos_d.slot == 4'd0)  st_d.sdata = tw[pos_d.bitp[3:0]];
        else                          st_d.sdata = sw[pos_d.bitp];
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdata_in = st_q.sdata;

    assert_idle_low_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pos_q.in_frame |-> !sdata_in);

    assert_tag_tail_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pos_q.in_frame && pos_q.slot == 4'd0 && pos_q.bitp < 5'd3) |-> !sdata_in);

    assert_notready_quiet_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pos_q.in_frame && !st_q.cont.ready) |-> !sdata_in);

    assert_echo_pad_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pos_q.in_frame && pos_q.slot == 4'd1 && (pos_q.bitp == 5'd19 || pos_q.bitp < 5'd12))
        |-> !sdata_in);

    assert_low_nibble_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pos_q.in_frame && pos_q.slot >= 4'd2 && pos_q.bitp < 5'd4) |-> !sdata_in);

    assert_reserved_zero_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pos_q.in_frame && (pos_q.slot == 4'd5 || pos_q.slot >= 4'd7)) |-> !sdata_in);

endmodule

// File: tb/sim_aclink_tx_frame.sv
module sim_aclink_tx_frame;

    localparam int RF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_index = '0;
    logic [15:0] rd_data = '0;
    logic [15:0] rec_left = '0, rec_right = '0, rec_mic = '0;
    logic [2:0]  rec_vld = '0;
    logic        sdata_in;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // bench model of request / readiness
    int          m_frames = 0;
    bit          m_pend = 0;
    logic [6:0]  m_idx = '0;
    logic [15:0] m_dat = '0;

    always #2 clk = ~clk;

    aclink_tx_frame #(.READY_FRAMES(RF)) u0 (
        .bit_clk(clk), .rst_n(rst_n), .sync(sync), .rd_req(rd_req),
        .rd_index(rd_index), .rd_data(rd_data), .rec_left(rec_left),
        .rec_right(rec_right), .rec_mic(rec_mic), .rec_vld(rec_vld),
        .sdata_in(sdata_in)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_frame(input bit rdy, input bit act,
        input logic [6:0] idx, input logic [15:0] dat, input logic [15:0] l,
        input logic [15:0] r, input logic [15:0] m, input logic [2:0] v);
        logic [15:0] tag;
        logic [19:0] s1, s2, s3, s4, s6;
        bit a;
        logic [2:0] vv;
        a  = rdy & act;
        vv = rdy ? v : 3'b000;
        tag = {rdy, a, a, vv[0], vv[1], 1'b0, vv[2], 6'b0, 3'b0};
        s1 = a     ? {1'b0, idx, 12'h000} : 20'h0;
        s2 = a     ? {dat, 4'h0} : 20'h0;
        s3 = vv[0] ? {l, 4'h0} : 20'h0;
        s4 = vv[1] ? {r, 4'h0} : 20'h0;
        s6 = vv[2] ? {m, 4'h0} : 20'h0;
        return {tag, s1, s2, s3, s4, 20'h0, s6, 120'h0};
    endfunction

    task automatic pulse_req(input logic [6:0] ri, input logic [15:0] rd);
        @(posedge clk); #1;
        rd_req = 1'b1; rd_index = ri; rd_data = rd;
        @(posedge clk); #1;
        rd_req = 1'b0;
        m_pend = 1; m_idx = ri; m_dat = rd;
    endtask

    // one frame; req_at >= 0 raises a request at that bit time within the frame
    task automatic run_frame(input int req_at, input logic [6:0] ri, input logic [15:0] rd);
        logic [255:0] got, exp;
        bit rdy, act;
        logic [6:0] e_idx;
        logic [15:0] e_dat;
        rdy   = (m_frames >= RF);
        act   = rdy & m_pend;
        e_idx = m_idx;
        e_dat = m_dat;
        if (rdy) m_pend = 0;
        m_frames++;
        exp = exp_frame(rdy, act, e_idx, e_dat, rec_left, rec_right, rec_mic, rec_vld);
        @(posedge clk); #1;
        sync = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 256; i++) begin
            #1;
            got[255-i] = sdata_in;
            if (i == 15) sync = 1'b0;
            if (i == req_at) begin
                rd_req = 1'b1; rd_index = ri; rd_data = rd;
                m_pend = 1; m_idx = ri; m_dat = rd;
            end else begin
                rd_req = 1'b0;
            end
            @(posedge clk);
        end
        #1;
        rd_req = 1'b0;
        chk(rdy ? "R4 tag slot" : "R5 not-ready tag slot", {4'h0, got[255:240]}, {4'h0, exp[255:240]});
        chk("R6 slot1 echo (R10 timing)", got[239:220], exp[239:220]);
        chk("R7 slot2 data (R11 last wins)", got[219:200], exp[219:200]);
        chk("R8 slot3 left", got[199:180], exp[199:180]);
        chk("R8 slot4 right", got[179:160], exp[179:160]);
        chk("R8 slot6 mic", got[139:120], exp[139:120]);
        chk("R9 slot5 reserved", got[159:140], 20'h0);
        chk("R9 slots7-12 reserved", {19'h0, |got[119:0]}, 20'h0);
        chk("R3 idle after last bit", {19'h0, sdata_in}, 20'h0);
        if (!rdy) chk("R5 whole frame zero", {19'h0, |got}, 20'h0);
        if (rdy) chk("R2 ready bit is first bit", {19'h0, got[255]}, 20'h1);
    endtask

    task automatic rand_samples();
        rec_left  = 16'($urandom);
        rec_right = 16'($urandom);
        rec_mic   = 16'($urandom);
        rec_vld   = 3'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20511));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 chk("R1 during reset", {19'h0, sdata_in}, 20'h0);
        rst_n = 1'b1;
        repeat (5) begin
            @(posedge clk); #1;
            chk("R1 idle after reset", {19'h0, sdata_in}, 20'h0);
        end

        // R5 + R10: two not-ready frames, request during the second is held
        rand_samples();
        run_frame(-1, 7'h00, 16'h0000);
        rec_vld = 3'b111;
        run_frame(100, 7'h26, 16'hA5C3);
        // first ready frame answers it
        rand_samples();
        run_frame(-1, 7'h00, 16'h0000);
        // R10: answered once only
        rand_samples();
        run_frame(-1, 7'h00, 16'h0000);
        // R10: request on the first bit of the frame waits a frame
        rand_samples();
        run_frame(0, 7'h7F, 16'hFFFF);
        run_frame(-1, 7'h00, 16'h0000);
        // R11: last of two requests wins
        pulse_req(7'h1A, 16'h1111);
        pulse_req(7'h1C, 16'h8000);
        rec_left = 16'h8000; rec_right = 16'h7FFF; rec_mic = 16'hFFFF; rec_vld = 3'b101;
        run_frame(-1, 7'h00, 16'h0000);
        // random frames
        for (int f = 0; f < 30; f++) begin
            int ra;
            rand_samples();
            if ($urandom_range(0, 3) == 0) pulse_req(7'($urandom), 16'($urandom));
            ra = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 255)) : -1;
            run_frame(ra, 7'($urandom), 16'($urandom));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule